// File: doc/BRIEF.md
# ADC power-mode sequencer

This block governs power and clocking for an analog-to-digital converter that has two converters and a voltage reference. It holds one 16-bit control word on a simple single-register write port with a continuous read view. The word sets three power-down enables, an auto power-down enable, an auto-standby enable and a 6-bit warm-up count. From the word the block drives the power-down controls, a clock-source select (conversion clock or standby clock) and one current-mode output shared by both converters.

The scan engine asks for a scan with a request pulse and reports when it has gone idle. When auto standby is active, the block switches to the conversion clock and normal current as the request is taken, counts the programmed warm-up, and then returns a one-cycle go strobe. When the engine is idle again, it goes back to the standby clock and standby current. Each unit has a power status flag. The flag sets as soon as that unit is powered down, and clears only once the warm-up count has run after power-up.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset the read word is 0x00D7: warm-up count 13, auto power-down off, auto standby off, all three power-down bits set, all status flags clear. After reset `scan_go`, `clk_sel_stby` and `cur_standby` are 0.
- R2: A write stores the writable fields, and both the read word and the outputs show them from the next cycle. The writable fields are bit 15 (auto standby), bits 9:4 (warm-up count), bit 3 (auto power-down) and bits 2:0 (power-down: bit 2 reference, bit 1 converter B, bit 0 converter A). The power-down bits drive `pd_ref`, `pd_conv_b` and `pd_conv_a`.
- R3: Bits 14:13 always read 0. Bits 12:10 are the status flags (bit 12 reference, bit 11 converter B, bit 10 converter A). Written values in bits 14:10 are ignored.
- R4: A unit's status flag reads 1 in the cycle after a write that sets its power-down bit, which is the same cycle in which the power-down bit itself reads 1.
- R5: With auto power-down off, a write at edge E0 that clears a set power-down bit with warm-up count D clears that unit's status flag at edge E0+D. When D is 0 the flag clears at E0 itself.
- R6: While auto power-down is set, a pending status clear is frozen and the flag stays 1. The countdown resumes once auto power-down is cleared.
- R7: Auto standby is in effect only when bit 15 is 1 and bit 3 is 0. While it is in effect and no scan is pending or running, `clk_sel_stby` and `cur_standby` are 1. Otherwise they are 0.
- R8: With auto standby in effect, a request sampled at edge k selects the conversion clock and normal current at edge k and raises `scan_go` at edge k+D+1, where D is the warm-up count.
- R9: Without auto standby, a request sampled at edge k raises `scan_go` at edge k.
- R10: `scan_go` is high for exactly one cycle, and only while the conversion clock is selected.
- R11: After a scan, `engine_idle` high (outside the `scan_go` cycle) returns the block to idle at the next edge, where auto standby selects the standby clock and standby current again.
- R12: A request that arrives during the warm-up or a running scan neither restarts the count nor is lost. It is held and started once the block is back at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word with status flags |
| scan_req | input | 1 | Scan request from the scan engine |
| engine_idle | input | 1 | Scan engine is idle |
| scan_go | output | 1 | One-cycle strobe: scan may begin |
| clk_sel_stby | output | 1 | 1 selects the standby clock, 0 the conversion clock |
| cur_standby | output | 1 | 1 puts both converters in standby current |
| pd_ref | output | 1 | Power-down enable, voltage reference |
| pd_conv_b | output | 1 | Power-down enable, converter B |
| pd_conv_a | output | 1 | Power-down enable, converter A |

## Verification
The properties assume that the scan engine drops `engine_idle` in the cycle after it sees `scan_go` and raises it only once its scan is done. They also assume that reset is held for several edges at start-up. The stimulus keeps to this: each `scan_go` seen is answered by lowering `engine_idle` at the next falling edge, and `engine_idle` is raised again only a few cycles later. Requests are single-cycle pulses, including the extra one placed inside the warm-up window. Control writes arrive only between scans, so the auto-standby setting does not change while a warm-up count is running.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  localparam int REG_W  = 16;
  localparam int DLY_W  = 6;
  localparam int N_UNIT = 3;

  // field positions that the decode logic relies on
  localparam int B_ASB     = 15;
  localparam int B_STAT_LO = 10;
  localparam int B_DLY_LO  = 4;
  localparam int B_APD     = 3;

  // writable bits: auto standby, delay, auto power-down, power-downs
  localparam logic [REG_W-1:0] WR_MASK = 16'h83FF;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WARM = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/adc_pwr_regs.sv
module adc_pwr_regs
  import adc_pwr_pkg::*;
#(
  parameter int RST_DLY = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [N_UNIT-1:0] stat,
  output logic [REG_W-1:0]  ctl_q,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [REG_W-1:0] PD_ALL  = REG_W'((1 << N_UNIT) - 1);
  localparam logic [REG_W-1:0] RST_VAL = (REG_W'(RST_DLY) << B_DLY_LO) | PD_ALL;

  // only writable bits are ever stored; the rest stay zero
  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= RST_VAL & WR_MASK;
    else if (wr_en)
      ctl_q <= wr_data & WR_MASK;
  end

  assign rd_data = ctl_q | (REG_W'(stat) << B_STAT_LO);
endmodule

// File: rtl/adc_pwr_stat.sv
module adc_pwr_stat #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             pd_new,
  input  logic             apd_new,
  input  logic [DLY_W-1:0] dly_new,
  input  logic             pd_q,
  input  logic             apd_q,
  output logic             stat_q
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      cnt    <= '0;
    end else if (wr_en && pd_new) begin
      // power-down takes effect at once
      stat_q <= 1'b1;
      cnt    <= '0;
    end else if (wr_en && pd_q) begin
      // power-up: arm the settle countdown
      cnt <= dly_new;
      if (dly_new == '0 && !apd_new)
        stat_q <= 1'b0;
    end else if (stat_q && !pd_q && !apd_q) begin
      if (cnt != '0)
        cnt <= cnt - DLY_W'(1);
      if (cnt <= DLY_W'(1))
        stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_pwr_scan.sv
module adc_pwr_scan
  import adc_pwr_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_sb,
  input  logic [DLY_W-1:0] dly,
  input  logic             scan_req,
  input  logic             engine_idle,
  output logic             scan_go,
  output logic             clk_stby,
  output logic             cur_stby
);
  sq_state_t        st, nxt;
  logic [DLY_W-1:0] cnt;
  logic             pend;
  logic             go, ld;

  always_comb begin
    nxt = st;
    go  = 1'b0;
    ld  = 1'b0;
    case (st)
      SQ_IDLE: begin
        if (scan_req || pend) begin
          if (auto_sb) begin
            nxt = SQ_WARM;
            ld  = 1'b1;
          end else begin
            nxt = SQ_RUN;
            go  = 1'b1;
          end
        end
      end
      SQ_WARM: begin
        if (cnt == '0) begin
          nxt = SQ_RUN;
          go  = 1'b1;
        end
      end
      SQ_RUN: begin
        if (engine_idle && !scan_go)
          nxt = SQ_IDLE;
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      pend     <= 1'b0;
      scan_go  <= 1'b0;
      clk_stby <= 1'b0;
      cur_stby <= 1'b0;
    end else begin
      st       <= nxt;
      scan_go  <= go;
      clk_stby <= auto_sb && (nxt == SQ_IDLE);
      cur_stby <= auto_sb && (nxt == SQ_IDLE);
      if (ld)
        cnt <= dly;
      else if (st == SQ_WARM && cnt != '0)
        cnt <= cnt - DLY_W'(1);
      if (st == SQ_IDLE && (go || ld))
        pend <= 1'b0;
      else if (scan_req && st != SQ_IDLE)
        pend <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int RST_DLY = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             scan_req,
  input  logic             engine_idle,
  output logic             scan_go,
  output logic             clk_sel_stby,
  output logic             cur_standby,
  output logic             pd_ref,
  output logic             pd_conv_b,
  output logic             pd_conv_a
);
  logic [REG_W-1:0]  ctl_q;
  logic [N_UNIT-1:0] stat;

  adc_pwr_regs #(.RST_DLY(RST_DLY)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .stat    (stat),
    .ctl_q   (ctl_q),
    .rd_data (rd_data)
  );

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    adc_pwr_stat #(.DLY_W(DLY_W)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .pd_new  (wr_data[u]),
      .apd_new (wr_data[B_APD]),
      .dly_new (wr_data[B_DLY_LO +: DLY_W]),
      .pd_q    (ctl_q[u]),
      .apd_q   (ctl_q[B_APD]),
      .stat_q  (stat[u])
    );
  end

  adc_pwr_scan #(.DLY_W(DLY_W)) u_scan (
    .clk         (clk),
    .rst         (rst),
    .auto_sb     (ctl_q[B_ASB] & ~ctl_q[B_APD]),
    .dly         (ctl_q[B_DLY_LO +: DLY_W]),
    .scan_req    (scan_req),
    .engine_idle (engine_idle),
    .scan_go     (scan_go),
    .clk_stby    (clk_sel_stby),
    .cur_stby    (cur_standby)
  );

  assign pd_conv_a = ctl_q[0];
  assign pd_conv_b = ctl_q[1];
  assign pd_ref    = ctl_q[2];
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_pd_a,
  input logic       stat_a,
  input logic       pd_a,
  input logic       apd_q,
  input logic [1:0] rd_res,
  input logic       scan_go,
  input logic       clk_stby
);
  // R10
  scan_go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_go |=> !scan_go);

  // R10
  go_conv_clk_chk: assert property (@(posedge clk) disable iff (rst)
    scan_go |-> !clk_stby);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_res == 2'b00);

  // R4
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pd_a) |=> stat_a);

  // R5
  status_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_a) |-> !pd_a);

  // R7
  apd_no_standby_chk: assert property (@(posedge clk) disable iff (rst)
    $past(apd_q) |-> !clk_stby);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_pd_a  (wr_data[0]),
  .stat_a   (rd_data[10]),
  .pd_a     (pd_conv_a),
  .apd_q    (rd_data[3]),
  .rd_res   (rd_data[14:13]),
  .scan_go  (scan_go),
  .clk_stby (clk_sel_stby)
);

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/1ps
module sim_adc_pwr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        scan_req = 1'b0;
  logic        engine_idle = 1'b1;
  logic [15:0] rd_data;
  logic        scan_go, clk_sel_stby, cur_standby, pd_ref, pd_conv_b, pd_conv_a;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adc_pwr_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .scan_req(scan_req), .engine_idle(engine_idle), .scan_go(scan_go),
    .clk_sel_stby(clk_sel_stby), .cur_standby(cur_standby),
    .pd_ref(pd_ref), .pd_conv_b(pd_conv_b), .pd_conv_a(pd_conv_a)
  );

  // {write word, expected read word}; status stays 111 throughout
  localparam logic [31:0] VEC [4] = '{
    32'h8017_9C17, 32'h7C3F_1C3F, 32'hE0F7_9CF7, 32'h00D7_1CD7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic scan_imm(input string req);
    @(negedge clk);
    scan_req = 1'b1;
    @(negedge clk);
    scan_req = 1'b0;
    chk(req, 32'(scan_go), 32'd1);
    engine_idle = 1'b0;
    @(negedge clk);
    chk("R10 go lasts one cycle", 32'(scan_go), 32'd0);
    engine_idle = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, go_n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset word", 32'(rd_data), 32'h00D7);
    chk("R1 reset power-downs", 32'({pd_ref, pd_conv_b, pd_conv_a}), 32'h7);
    chk("R1 reset scan_go", 32'(scan_go), 32'd0);
    chk("R1 reset clock select", 32'(clk_sel_stby), 32'd0);
    chk("R1 reset current mode", 32'(cur_standby), 32'd0);

    // R2 R3 R4 vector table
    for (int i = 0; i < 4; i++) begin
      wr_reg(VEC[i][31:16]);
      chk("R2 R3 R4 table readback", 32'(rd_data), 32'(VEC[i][15:0]));
      chk("R2 table power-down pins", 32'({pd_ref, pd_conv_b, pd_conv_a}), 32'(VEC[i][18:16]));
    end

    // R5 delayed clear, D=3
    wr_reg(16'h0034);
    repeat (2) @(negedge clk);
    chk("R5 status held before delay", 32'(rd_data[12:10]), 32'h7);
    @(negedge clk);
    chk("R5 status cleared after delay", 32'(rd_data[12:10]), 32'h4);

    // R5 zero delay clears at the write edge
    wr_reg(16'h0007);
    chk("R4 all status set", 32'(rd_data), 32'h1C07);
    wr_reg(16'h0000);
    chk("R5 zero delay clear", 32'(rd_data), 32'h0000);

    // R4 single unit
    wr_reg(16'h0001);
    chk("R4 status A sets with power-down", 32'(rd_data), 32'h0401);

    // R6 auto power-down freezes the clear
    wr_reg(16'h0037);
    chk("R6 setup", 32'(rd_data), 32'h1C37);
    wr_reg(16'h0038);
    repeat (6) @(negedge clk);
    chk("R6 status frozen", 32'(rd_data), 32'h1C38);
    wr_reg(16'h0030);
    repeat (5) @(negedge clk);
    chk("R6 countdown resumes", 32'(rd_data), 32'h0030);

    // R7 auto standby at idle, D=5
    wr_reg(16'h8050);
    repeat (2) @(negedge clk);
    chk("R7 standby clock at idle", 32'(clk_sel_stby), 32'd1);
    chk("R7 standby current at idle", 32'(cur_standby), 32'd1);

    // R8 R12 warm-up with a second request inside the window
    @(negedge clk);
    scan_req = 1'b1;
    n = 0;
    go_n = 0;
    while (go_n == 0 && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        scan_req = 1'b0;
        chk("R8 conversion clock on request", 32'(clk_sel_stby), 32'd0);
        chk("R8 normal current on request", 32'(cur_standby), 32'd0);
      end
      if (n == 3) scan_req = 1'b1;
      if (n == 4) scan_req = 1'b0;
      if (scan_go) begin
        go_n = n;
        engine_idle = 1'b0;
      end
    end
    chk("R8 R12 go after warm-up not restarted", 32'(go_n), 32'd7);
    @(negedge clk);
    chk("R10 go single cycle", 32'(scan_go), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 conversion clock while running", 32'(clk_sel_stby), 32'd0);

    // R11 return to standby, then R12 held request starts
    engine_idle = 1'b1;
    n = 0;
    go_n = 0;
    while (go_n == 0 && n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk("R11 standby clock after idle", 32'(clk_sel_stby), 32'd1);
        chk("R11 standby current after idle", 32'(cur_standby), 32'd1);
      end
      if (scan_go) begin
        go_n = n;
        engine_idle = 1'b0;
      end
    end
    chk("R12 held request serviced", 32'(go_n), 32'd8);
    @(negedge clk);
    engine_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 back in standby", 32'(clk_sel_stby), 32'd1);

    // R9 no auto standby
    wr_reg(16'h0050);
    repeat (2) @(negedge clk);
    chk("R7 no standby when disabled", 32'(clk_sel_stby), 32'd0);
    scan_imm("R9 immediate go");

    // R7 auto power-down overrides auto standby
    wr_reg(16'h8058);
    repeat (2) @(negedge clk);
    chk("R7 override clock", 32'(clk_sel_stby), 32'd0);
    chk("R7 override current", 32'(cur_standby), 32'd0);
    scan_imm("R9 immediate go under override");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule